// File: doc/BRIEF.md
# Binary Rate Pulse-Stream Generator

This block turns an unsigned W-bit code into a serial train of identical one-clock pulses. A free-running W-bit state counter steps through all 2^W values, and each value is one slot of the conversion period. In any slot, the bit that the next increment will set picks one weighted line. A line that fires in 2^(W-1-k) slots of the period is gated by the code bit of the same binary weight. The pulse output is the OR of the gated lines. Over one period, the number of pulses equals the code exactly, and each code bit's pulses are spread evenly through the period rather than grouped in a burst.

The code input is captured once per period, at the slot where the counter wraps. A downstream consumer can change the code at any time without disturbing the period that is running. A one-cycle strobe marks the first slot of each period, so a counter or integrator downstream can align with it. A clock enable stalls the whole block. While it is low the state is held and both outputs stay low.

Top module: `pulse_rate_gen`

## Requirements
- R1: `start_o` is high for exactly one output cycle in every 2^W enabled ticks. That cycle carries the result of the tick taken in counter state 0, and is called period position 0.
- R2: The number of `pulse_o` cycles in one period equals the code latched for that period. A code of zero gives no pulses, and the all-ones code gives 2^W-1 pulses.
- R3: At period position p, let t be the number of consecutive one bits of p counted from bit 0. `pulse_o` is high exactly when t < W and bit W-1-t of the latched code is 1. Code bit W-1 therefore fires at every even position, and code bit 0 fires only at position 2^(W-1)-1.
- R4: In any state at most one weight line is active. In the all-ones state no line is active, so that slot never produces a pulse.
- R5: `code_i` is sampled only on the enabled tick taken in the all-ones state, and it applies to the period that starts on the next tick. Changes at any other time have no effect on the running period's pulses.
- R6: A clock edge with `en` low holds the counter. That edge also drives `pulse_o` and `start_o` low for the following cycle.
- R7: Synchronous reset (`rst` high) forces the counter to the all-ones state, clears the latched code and drives both outputs low. The first enabled tick after reset loads the code and gives no pulse. The second enabled tick starts a period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock enable for the counter and outputs |
| code_i | input | W | Unsigned code giving pulses per period |
| pulse_o | output | 1 | Registered equal-weight pulse stream |
| start_o | output | 1 | One-cycle strobe at period position 0 |

## Verification
The bench predicts every output cycle from the trailing-ones rule. It therefore catches a design that pairs the most frequent line with the code's low bit: such a design would emit the wrong pulse count for most codes. The bench changes `code_i` on every cycle over many periods. A block that used the live code instead of the latched one would mix codes within a period. Directed runs cover the zero code, the all-ones code and single-bit codes. The all-ones code exposes a design that lets the wrap slot fire, because that design would emit 2^W pulses. Random stalls and a reset in mid-period catch a counter that keeps advancing with the enable low, and a restart that strobes one tick too early.

// File: rtl/prg_pkg.sv
package prg_pkg;

    // Default code width of the generator.
    localparam int unsigned PRG_DEF_W = 4;

    // Registered output flags of the generator.
    typedef struct packed {
        logic pulse;
        logic start;
    } prg_flags_t;

endpackage

// File: rtl/prg_counter.sv
module prg_counter #(
    parameter int unsigned W = prg_pkg::PRG_DEF_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    output logic [W-1:0] state_o,
    output logic         wrap_o
);

    localparam logic [W-1:0] STEP = {{(W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [W-1:0] state;
    } ctr_t;

    ctr_t ctr_d;
    ctr_t ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (en) begin
            ctr_d.state = ctr_q.state + STEP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctr_q.state <= '1;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign state_o = ctr_q.state;
    assign wrap_o  = &ctr_q.state;

    // R1
    step_seq_chk: assert property (@(posedge clk) disable iff (rst)
        en |=> (state_o == $past(state_o) + STEP));

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(state_o));

endmodule

// File: rtl/prg_weight_dec.sv
module prg_weight_dec #(
    parameter int unsigned W = prg_pkg::PRG_DEF_W
) (
    input  logic [W-1:0] state_i,
    output logic [W-1:0] line_o
);

    // Line k is active when the coming increment sets bit k:
    // bits below k are all one and bit k is zero.
    for (genvar k = 0; k < W; k++) begin : g_line
        if (k == 0) begin : g_lsb
            assign line_o[k] = ~state_i[0];
        end else begin : g_upper
            assign line_o[k] = (&state_i[k-1:0]) & ~state_i[k];
        end
    end

endmodule

// File: rtl/prg_gate.sv
module prg_gate #(
    parameter int unsigned W = prg_pkg::PRG_DEF_W
) (
    input  logic [W-1:0] line_i,
    input  logic [W-1:0] code_i,
    output logic         hit_o
);

    logic [W-1:0] sel;

    // The most frequent line (k = 0) carries the heaviest code bit.
    for (genvar k = 0; k < W; k++) begin : g_pair
        assign sel[k] = line_i[k] & code_i[W-1-k];
    end

    assign hit_o = |sel;

endmodule

// File: rtl/pulse_rate_gen.sv
module pulse_rate_gen #(
    parameter int unsigned W = prg_pkg::PRG_DEF_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] code_i,
    output logic         pulse_o,
    output logic         start_o
);

    localparam logic [W-1:0] ST_FIRST = '0;
    localparam logic [W-1:0] ST_NEXT  = {{(W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [W-1:0]          code;
        prg_pkg::prg_flags_t   flags;
    } gen_t;

    gen_t         gen_d;
    gen_t         gen_q;
    logic [W-1:0] state;
    logic         wrap;
    logic [W-1:0] line;
    logic         hit;

    prg_counter #(.W(W)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .state_o (state),
        .wrap_o  (wrap)
    );

    prg_weight_dec #(.W(W)) u_dec (
        .state_i (state),
        .line_o  (line)
    );

    prg_gate #(.W(W)) u_gate (
        .line_i  (line),
        .code_i  (gen_q.code),
        .hit_o   (hit)
    );

    always_comb begin
        gen_d       = gen_q;
        gen_d.flags = '0;
        if (en) begin
            gen_d.flags.pulse = hit;
            gen_d.flags.start = (state == ST_FIRST);
            if (wrap) begin
                gen_d.code = code_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gen_q <= '0;
        end else begin
            gen_q <= gen_d;
        end
    end

    assign pulse_o = gen_q.flags.pulse;
    assign start_o = gen_q.flags.start;

    // Per-period pulse tally used by the count property below.
    logic [W:0] tally_q;
    logic       armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tally_q <= '0;
            armed_q <= 1'b0;
        end else begin
            tally_q <= (start_o ? '0 : tally_q) + {{W{1'b0}}, pulse_o};
            armed_q <= armed_q | start_o;
        end
    end

    // R2
    period_count_chk: assert property (@(posedge clk) disable iff (rst)
        (en && wrap && armed_q) |-> ((tally_q + {{W{1'b0}}, pulse_o}) == {1'b0, gen_q.code}));

    // R4
    one_line_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(line));

    // R4
    wrap_silent_chk: assert property (@(posedge clk) disable iff (rst)
        wrap |-> (line == '0));

    // R1
    strobe_pos_chk: assert property (@(posedge clk) disable iff (rst)
        start_o |-> (state == ST_NEXT));

    // R5
    code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(en && wrap) |=> $stable(gen_q.code));

    // R6
    stall_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!pulse_o && !start_o));

endmodule

// File: tb/pulse_rate_gen_tb_top.sv
module pulse_rate_gen_tb_top;

    localparam int W = 5;
    localparam int P = 1 << W;

    logic         clk  = 1'b0;
    logic         rst  = 1'b1;
    logic         en   = 1'b0;
    logic [W-1:0] code = '0;
    logic         pulse;
    logic         start;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pulse_rate_gen #(.W(W)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .code_i  (code),
        .pulse_o (pulse),
        .start_o (start)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Expected pulse at period position p for code c (R3 rule).
    function automatic bit fire(input int p, input logic [W-1:0] c);
        int t = 0;
        while (t < W && ((p >> t) & 1) == 1) t++;
        if (t >= W) return 1'b0;
        return c[W-1-t];
    endfunction

    // Monitor state
    bit           rst_prev = 1'b1;
    bit           last_en  = 1'b0;
    bit           started  = 1'b0;
    int           pos      = 0;
    int           cnt      = 0;
    int           pre      = 0;
    logic [W-1:0] exp_code = '0;
    logic [W-1:0] h1       = '0;
    logic [W-1:0] h2       = '0;

    always @(negedge clk) begin
        if (rst_prev) begin
            // R7: outputs low after a reset edge
            check(pulse == 1'b0, "R7 pulse after reset", int'(pulse), 0);
            check(start == 1'b0, "R7 strobe after reset", int'(start), 0);
            started = 1'b0;
            pre     = 0;
            h1      = '0;
            h2      = '0;
        end else if (!last_en) begin
            // R6: stalled edge gives quiet outputs
            check(pulse == 1'b0, "R6 pulse while stalled", int'(pulse), 0);
            check(start == 1'b0, "R6 strobe while stalled", int'(start), 0);
        end else if (!started) begin
            if (start) begin
                // R7: period begins on the second enabled tick
                check(pre == 1, "R7 ticks before first strobe", pre, 1);
                started  = 1'b1;
                pos      = 0;
                cnt      = 0;
                exp_code = h2;
                check(pulse == fire(pos, exp_code), "R3 pulse position", int'(pulse), int'(fire(pos, exp_code)));
                cnt += int'(pulse);
                pos++;
            end else begin
                check(pulse == 1'b0, "R7 no pulse on load tick", int'(pulse), 0);
                pre++;
            end
        end else begin
            if (pos == P) begin
                check(start == 1'b1, "R1 strobe at period edge", int'(start), 1);
                check(cnt == int'(exp_code), "R2 R5 pulses per period", cnt, int'(exp_code));
                pos      = 0;
                cnt      = 0;
                exp_code = h2;
            end else begin
                check(start == 1'b0, "R1 strobe inside period", int'(start), 0);
            end
            check(pulse == fire(pos, exp_code), "R3 pulse position", int'(pulse), int'(fire(pos, exp_code)));
            cnt += int'(pulse);
            pos++;
        end
        rst_prev = rst;
        last_en  = en && !rst;
        if (en && !rst) begin
            h2 = h1;
            h1 = code;
        end
    end

    task automatic step(input bit e, input logic [W-1:0] c);
        @(posedge clk);
        #2;
        en   = e;
        code = c;
    endtask

    initial begin
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
        // R2 zero code
        repeat (2 * P + 4) step(1'b1, '0);
        // R2 R4 all-ones code, wrap slot must stay silent
        repeat (2 * P) step(1'b1, '1);
        // R3 lowest code bit: single pulse mid-period
        repeat (2 * P) step(1'b1, W'(1));
        // R3 highest code bit: every even position
        repeat (2 * P) step(1'b1, W'(1 << (W - 1)));
        // R5 code changes every cycle
        for (int i = 0; i < 10 * P; i++) step(1'b1, W'($urandom));
        // R6 random stalls with changing code
        for (int i = 0; i < 8 * P; i++) step(($urandom % 4) != 0, W'($urandom));
        // R7 reset in mid-period
        repeat (P / 2) step(1'b1, W'(5'b10110));
        @(posedge clk);
        #2;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #2;
        rst = 1'b0;
        repeat (2 * P + 4) step(1'b1, W'(5'b10110));
        for (int i = 0; i < 3 * P; i++) step(1'b1, W'($urandom));
        repeat (4) @(posedge clk);
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            report();
            $finish;
        end
    end

endmodule